// File: doc/BRIEF.md
# Four-to-Six Octet Clock-Crossing Gearbox

This block takes a stream of 4-octet words on a fast link clock and delivers it as 6-octet beats on a slower device clock. The two clocks are in a fixed 3:2 ratio (link:device), so the octet rate is the same on both sides. Every output beat holds whole frames: two 3-octet frames, or one 6-octet frame. A start-of-frame mask tells the next stage where each frame begins. The output side is held idle until a release pulse arrives. From then on it reads one beat per device clock, so the delay from that pulse to the first beat is fixed.

Octets are staged in 12-octet slots, 12 being the least common multiple of the two widths. Three input words fill a slot, and the slot drains as two output beats. Slot pointers cross between the clock domains in Gray code. A slot becomes visible to the reader only after its last word has been written. Each side keeps a sticky error flag: the link side for overflow, the device side for underflow.

When the input and output widths are equal, a generate branch replaces the slot buffer with a single register stage. That stage runs on the device clock alone.

Top module: `octet_gearbox`

## Requirements
- R1: Output octets equal the accepted input octets in order, with none lost or repeated. Input octet k is `lk_data[8k+7:8k]` and output octet j is `dv_data[8j+7:8j]`. The first accepted word's octet 0 becomes output octet 0 of a slot's first beat.
- R2: `dv_valid` stays low until a `dv_release` pulse has been sampled, whatever data is buffered.
- R3: If a complete slot is already visible on the device side, `dv_valid` is low after the device clock edge that samples `dv_release`, and high after the following edge.
- R4: Once reading has started and input arrives at full rate, `dv_valid` is high on every device clock, and the two beats of a slot come out on consecutive cycles.
- R5: A slot is never read until all three of its input words have been written. Input that fills only part of a slot stays buffered.
- R6: With `frame_is_six` = 0 (3-octet frames), `dv_sof` is 6'b001001 on every valid beat. With `frame_is_six` = 1 (6-octet frames), it is 6'b000001. It is zero whenever `dv_valid` is low.
- R7: A word offered at the start of a slot while all SLOT_DEPTH slots are unread is dropped, and `lk_overflow` goes high. The flag stays high until reset. The slots already stored are still delivered intact.
- R8: If, while reading, no complete slot is visible at a slot boundary, `dv_valid` goes low and `dv_underflow` goes high. The flag stays high until reset.
- R9: Right after reset, `dv_valid`, `dv_sof`, `lk_overflow` and `dv_underflow` are all zero.
- R10: With equal widths (bypass), a word presented with `lk_valid` appears on `dv_data` one device clock later, together with `dv_valid` and the frame mask. This happens only after release, and both error flags stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link-side clock |
| link_rst_n | input | 1 | Link-side asynchronous reset, active low |
| lk_data | input | IN_OCTETS*8 | Input word, octet 0 in the low bits |
| lk_valid | input | 1 | Input word strobe |
| dev_clk | input | 1 | Device-side clock |
| dev_rst_n | input | 1 | Device-side asynchronous reset, active low |
| dv_release | input | 1 | One-cycle pulse that allows reading to start |
| frame_is_six | input | 1 | Static frame size: 0 for 3 octets, 1 for 6 octets |
| dv_data | output | OUT_OCTETS*8 | Output beat |
| dv_valid | output | 1 | Output beat valid |
| dv_sof | output | OUT_OCTETS | Start-of-frame mask, one bit per output octet |
| lk_overflow | output | 1 | Sticky overflow flag, link domain |
| dv_underflow | output | 1 | Sticky underflow flag, device domain |

## Verification
The bench builds two instances. The main one uses the default 4-to-6 widths with eight slots. In that instance three words fill a slot and two beats drain it. Twenty-four words fill the buffer exactly, so the 25th word hits the overflow boundary with no timing slack. The second instance uses 6-to-6 widths, which selects the bypass branch, so the single-register path is checked on the same shared device clock. The link and device clocks are generated in an exact 3:2 ratio, so steady full-rate streaming should run without underflow, and stopping the input produces one.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    typedef enum logic {
        FRAME_3 = 1'b0,
        FRAME_6 = 1'b1
    } frame_sel_e;

    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    // Marks octet idx of a beat when a frame starts there.
    function automatic logic sof_bit(input frame_sel_e fs, input int idx);
        return (fs == FRAME_6) ? (idx % 6 == 0) : (idx % 3 == 0);
    endfunction

endpackage

// File: rtl/gbx_sync.sv
module gbx_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/gbx_link_side.sv
module gbx_link_side
    import gbx_pkg::*;
#(
    parameter int IN_OCTETS   = 4,
    parameter int SLOT_OCTETS = 12,
    parameter int SLOT_DEPTH  = 8,
    parameter int PW          = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [IN_OCTETS*8-1:0]               in_data,
    input  logic                                 in_valid,
    input  logic [PW-1:0]                        rd_gray_sync,
    output logic [PW-1:0]                        wr_gray,
    output logic [SLOT_DEPTH*SLOT_OCTETS*8-1:0]  mem_flat,
    output logic                                 overflow
);
    localparam int IN_W  = IN_OCTETS * 8;
    localparam int WPS   = SLOT_OCTETS / IN_OCTETS;
    localparam int WW    = (WPS > 1) ? $clog2(WPS) : 1;
    localparam int MEM_W = SLOT_DEPTH * SLOT_OCTETS * 8;
    localparam logic [WW-1:0] LAST_WORD = WW'(WPS - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [WW-1:0] word;
        logic          ovf;
    } link_st_t;

    link_st_t          st_q, st_d;
    logic [MEM_W-1:0]  mem_q;
    logic [PW-1:0]     rd_bin;
    logic [PW-1:0]     fill;
    logic              full;
    logic              wr_en;
    int                wr_off;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rd_bin[i] = ^(rd_gray_sync >> i);
        end
        fill   = st_q.ptr - rd_bin;
        full   = (fill == PW'(SLOT_DEPTH));
        wr_off = (int'(st_q.ptr[PW-2:0]) * SLOT_OCTETS + int'(st_q.word) * IN_OCTETS) * 8;
        st_d   = st_q;
        wr_en  = 1'b0;
        if (in_valid) begin
            if ((st_q.word == '0) && full) begin
                st_d.ovf = 1'b1;
            end else begin
                wr_en = 1'b1;
                if (st_q.word == LAST_WORD) begin
                    st_d.word = '0;
                    st_d.ptr  = st_q.ptr + 1'b1;
                end else begin
                    st_d.word = st_q.word + 1'b1;
                end
            end
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_off +: IN_W] <= in_data;
        end
    end

    assign wr_gray  = st_q.gray;
    assign mem_flat = mem_q;
    assign overflow = st_q.ovf;

    // R7: the writer never runs more than SLOT_DEPTH slots ahead of the reader it sees
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PW'(SLOT_DEPTH));

    // R7: the overflow flag holds until reset
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
endmodule

// File: rtl/gbx_dev_side.sv
module gbx_dev_side
    import gbx_pkg::*;
#(
    parameter int OUT_OCTETS  = 6,
    parameter int SLOT_OCTETS = 12,
    parameter int SLOT_DEPTH  = 8,
    parameter int PW          = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 rel_pulse,
    input  logic                                 frame_six,
    input  logic [PW-1:0]                        wr_gray_sync,
    input  logic [SLOT_DEPTH*SLOT_OCTETS*8-1:0]  mem_flat,
    output logic [PW-1:0]                        rd_gray,
    output logic [OUT_OCTETS*8-1:0]              out_data,
    output logic                                 out_valid,
    output logic [OUT_OCTETS-1:0]                out_sof,
    output logic                                 underflow
);
    localparam int OUT_W = OUT_OCTETS * 8;
    localparam int BPS   = SLOT_OCTETS / OUT_OCTETS;
    localparam int BW    = (BPS > 1) ? $clog2(BPS) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(BPS - 1);

    typedef struct packed {
        logic [PW-1:0]         ptr;
        logic [PW-1:0]         gray;
        logic [BW-1:0]         beat;
        logic                  released;
        logic                  running;
        logic                  valid;
        logic [OUT_OCTETS-1:0] sof;
        logic [OUT_W-1:0]      data;
        logic                  unf;
    } dev_st_t;

    dev_st_t               st_q, st_d;
    logic [PW-1:0]         wr_bin;
    logic                  rdy;
    logic                  emit;
    logic [OUT_OCTETS-1:0] sof_pat;
    int                    rd_off;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wr_bin[i] = ^(wr_gray_sync >> i);
        end
        for (int j = 0; j < OUT_OCTETS; j++) begin
            sof_pat[j] = sof_bit(frame_sel_e'(frame_six), j);
        end
        rdy    = (wr_bin != st_q.ptr);
        rd_off = (int'(st_q.ptr[PW-2:0]) * SLOT_OCTETS + int'(st_q.beat) * OUT_OCTETS) * 8;

        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.sof      = '0;
        st_d.released = st_q.released | rel_pulse;
        emit          = 1'b0;

        if (!st_q.running) begin
            if (st_q.released && rdy) begin
                st_d.running = 1'b1;
                emit         = 1'b1;
            end
        end else if ((st_q.beat == '0) && !rdy) begin
            st_d.unf = 1'b1;
        end else begin
            emit = 1'b1;
        end

        if (emit) begin
            st_d.data  = mem_flat[rd_off +: OUT_W];
            st_d.valid = 1'b1;
            st_d.sof   = sof_pat;
            if (st_q.beat == LAST_BEAT) begin
                st_d.beat = '0;
                st_d.ptr  = st_q.ptr + 1'b1;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_gray   = st_q.gray;
    assign out_data  = st_q.data;
    assign out_valid = st_q.valid;
    assign out_sof   = st_q.sof;
    assign underflow = st_q.unf;

    // R2: nothing leaves before a release has been registered
    p_hold_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.released |-> !st_q.valid);

    // R4: a slot's later beat follows its first beat on the next cycle
    p_beat_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && (st_q.beat != '0)) |=> st_q.valid);

    // R5: the reader never passes the writer pointer it has seen
    p_lag_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bin - st_q.ptr) <= PW'(SLOT_DEPTH));

    // R6: the mask is quiet on idle cycles and marks octet 0 on every beat
    p_sof_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |-> (st_q.sof == '0));
    p_sof_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> st_q.sof[0]);

    // R8: the underflow flag holds until reset
    p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf |=> st_q.unf);
endmodule

// File: rtl/octet_gearbox.sv
module octet_gearbox
    import gbx_pkg::*;
#(
    parameter int IN_OCTETS  = 4,
    parameter int OUT_OCTETS = 6,
    parameter int SLOT_DEPTH = 8
) (
    input  logic                    link_clk,
    input  logic                    link_rst_n,
    input  logic [IN_OCTETS*8-1:0]  lk_data,
    input  logic                    lk_valid,
    input  logic                    dev_clk,
    input  logic                    dev_rst_n,
    input  logic                    dv_release,
    input  logic                    frame_is_six,
    output logic [OUT_OCTETS*8-1:0] dv_data,
    output logic                    dv_valid,
    output logic [OUT_OCTETS-1:0]   dv_sof,
    output logic                    lk_overflow,
    output logic                    dv_underflow
);
    localparam int SLOT_OCTETS = lcm_f(IN_OCTETS, OUT_OCTETS);
    localparam int PW          = $clog2(SLOT_DEPTH) + 1;
    localparam int MEM_W       = SLOT_DEPTH * SLOT_OCTETS * 8;
    localparam int OUT_W       = OUT_OCTETS * 8;

    if (IN_OCTETS != OUT_OCTETS) begin : g_gearbox
        logic [PW-1:0]    wr_gray;
        logic [PW-1:0]    rd_gray;
        logic [PW-1:0]    wr_gray_dev;
        logic [PW-1:0]    rd_gray_link;
        logic [MEM_W-1:0] mem_flat;

        gbx_link_side #(
            .IN_OCTETS  (IN_OCTETS),
            .SLOT_OCTETS(SLOT_OCTETS),
            .SLOT_DEPTH (SLOT_DEPTH),
            .PW         (PW)
        ) u_link (
            .clk         (link_clk),
            .rst_n       (link_rst_n),
            .in_data     (lk_data),
            .in_valid    (lk_valid),
            .rd_gray_sync(rd_gray_link),
            .wr_gray     (wr_gray),
            .mem_flat    (mem_flat),
            .overflow    (lk_overflow)
        );

        gbx_sync #(.W(PW)) u_wr_to_dev (
            .clk  (dev_clk),
            .rst_n(dev_rst_n),
            .d    (wr_gray),
            .q    (wr_gray_dev)
        );

        gbx_sync #(.W(PW)) u_rd_to_link (
            .clk  (link_clk),
            .rst_n(link_rst_n),
            .d    (rd_gray),
            .q    (rd_gray_link)
        );

        gbx_dev_side #(
            .OUT_OCTETS (OUT_OCTETS),
            .SLOT_OCTETS(SLOT_OCTETS),
            .SLOT_DEPTH (SLOT_DEPTH),
            .PW         (PW)
        ) u_dev (
            .clk         (dev_clk),
            .rst_n       (dev_rst_n),
            .rel_pulse   (dv_release),
            .frame_six   (frame_is_six),
            .wr_gray_sync(wr_gray_dev),
            .mem_flat    (mem_flat),
            .rd_gray     (rd_gray),
            .out_data    (dv_data),
            .out_valid   (dv_valid),
            .out_sof     (dv_sof),
            .underflow   (dv_underflow)
        );
    end else begin : g_bypass
        typedef struct packed {
            logic                  released;
            logic                  valid;
            logic [OUT_OCTETS-1:0] sof;
            logic [OUT_W-1:0]      data;
        } byp_st_t;

        byp_st_t bp_q, bp_d;

        always_comb begin
            bp_d          = bp_q;
            bp_d.released = bp_q.released | dv_release;
            bp_d.valid    = bp_q.released & lk_valid;
            bp_d.sof      = '0;
            if (bp_d.valid) begin
                bp_d.data = OUT_W'(lk_data);
                for (int j = 0; j < OUT_OCTETS; j++) begin
                    bp_d.sof[j] = sof_bit(frame_sel_e'(frame_is_six), j);
                end
            end
        end

        always_ff @(posedge dev_clk or negedge dev_rst_n) begin
            if (!dev_rst_n) begin
                bp_q <= '0;
            end else begin
                bp_q <= bp_d;
            end
        end

        assign dv_data      = bp_q.data;
        assign dv_valid     = bp_q.valid;
        assign dv_sof       = bp_q.sof;
        assign lk_overflow  = 1'b0;
        assign dv_underflow = 1'b0;

        // R10: a bypassed beat is always the word offered one clock earlier
        p_bypass_lat_r10: assert property (@(posedge dev_clk) disable iff (!dev_rst_n)
            (bp_q.released && lk_valid) |=> (bp_q.valid && (bp_q.data == $past(OUT_W'(lk_data)))));
    end
endmodule

// File: tb/octet_gearbox_tb_top.sv
module octet_gearbox_tb_top;
    timeunit 1ps;
    timeprecision 1ps;

    logic        dev_clk = 1'b0;
    logic        link_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_data = '0;
    logic        lk_valid = 1'b0;
    logic        dv_release = 1'b0;
    logic        frame_six = 1'b0;
    logic [47:0] dv_data;
    logic        dv_valid;
    logic [5:0]  dv_sof;
    logic        lk_ovf;
    logic        dv_unf;

    logic [47:0] bp_in = '0;
    logic        bp_in_valid = 1'b0;
    logic        bp_release = 1'b0;
    logic [47:0] bp_out;
    logic        bp_valid;
    logic [5:0]  bp_sof;
    logic        bp_ovf;
    logic        bp_unf;

    int checks = 0;
    int fails = 0;
    int credit = 0;
    int beats = 0;
    int words_sent = 0;
    int cyc = 0;
    bit stream_on = 0;
    bit gap_mode = 0;
    bit drop_next = 0;
    bit release_seen = 0;
    byte unsigned exp_q[$];

    octet_gearbox dut_i (
        .link_clk(link_clk), .link_rst_n(rst_n), .lk_data(lk_data), .lk_valid(lk_valid),
        .dev_clk(dev_clk), .dev_rst_n(rst_n), .dv_release(dv_release), .frame_is_six(frame_six),
        .dv_data(dv_data), .dv_valid(dv_valid), .dv_sof(dv_sof),
        .lk_overflow(lk_ovf), .dv_underflow(dv_unf)
    );

    octet_gearbox #(.IN_OCTETS(6), .OUT_OCTETS(6)) byp_i (
        .link_clk(dev_clk), .link_rst_n(rst_n), .lk_data(bp_in), .lk_valid(bp_in_valid),
        .dev_clk(dev_clk), .dev_rst_n(rst_n), .dv_release(bp_release), .frame_is_six(frame_six),
        .dv_data(bp_out), .dv_valid(bp_valid), .dv_sof(bp_sof),
        .lk_overflow(bp_ovf), .dv_underflow(bp_unf)
    );

    // 125 MHz device clock; link clock is exactly 3/2 of it (three periods per 16 ns)
    initial forever #4000 dev_clk = ~dev_clk;
    initial forever begin
        #2667 link_clk = ~link_clk;
        #2667 link_clk = ~link_clk;
        #2666 link_clk = ~link_clk;
        #2667 link_clk = ~link_clk;
        #2666 link_clk = ~link_clk;
        #2667 link_clk = ~link_clk;
    end

    function automatic logic [5:0] exp_sof(input logic six);
        return six ? 6'b000001 : 6'b001001;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic wait_dev(input int n);
        repeat (n) @(negedge dev_clk);
    endtask

    task automatic do_reset(input bit six);
        rst_n = 1'b0;
        stream_on = 0;
        gap_mode = 0;
        credit = 0;
        drop_next = 0;
        release_seen = 0;
        dv_release = 1'b0;
        bp_release = 1'b0;
        bp_in_valid = 1'b0;
        frame_six = six;
        wait_dev(4);
        exp_q.delete();
        words_sent = 0;
        beats = 0;
        rst_n = 1'b1;
        @(negedge dev_clk);
        chk(dv_valid == 1'b0, "R9", "valid after reset", 64'(dv_valid), 64'd0);
        chk(dv_sof == 6'd0, "R9", "sof after reset", 64'(dv_sof), 64'd0);
        chk(lk_ovf == 1'b0, "R9", "overflow after reset", 64'(lk_ovf), 64'd0);
        chk(dv_unf == 1'b0, "R9", "underflow after reset", 64'(dv_unf), 64'd0);
    endtask

    task automatic pulse_release();
        @(negedge dev_clk);
        dv_release = 1'b1;
        release_seen = 1;
        @(negedge dev_clk);
        dv_release = 1'b0;
    endtask

    // Link-side stimulus: random words, optional random gaps, scoreboard fill
    always @(negedge link_clk) begin : drv
        logic [31:0] w;
        bit go;
        if (rst_n && (stream_on || credit > 0)) begin
            w = $urandom;
            go = !gap_mode || ($urandom % 4 != 0);
            lk_valid = go;
            lk_data = w;
            if (go) begin
                if (credit > 0) credit--;
                if (drop_next) begin
                    drop_next = 0;
                end else begin
                    for (int k = 0; k < 4; k++) exp_q.push_back(w[k*8 +: 8]);
                    words_sent++;
                end
            end
        end else begin
            lk_valid = 1'b0;
        end
    end

    // Device-side monitor: R1 data order, R2 release gating, R6 mask
    always @(negedge dev_clk) begin : mon
        logic [47:0] e;
        if (rst_n && dv_valid) begin
            beats++;
            chk(release_seen, "R2", "beat before release", 64'(dv_valid), 64'd0);
            chk(dv_sof == exp_sof(frame_six), "R6", "frame mask", 64'(dv_sof), 64'(exp_sof(frame_six)));
            if (exp_q.size() < 6) begin
                chk(1'b0, "R1", "beat with no pending octets", 64'(dv_data), 64'd0);
            end else begin
                for (int k = 0; k < 6; k++) e[k*8 +: 8] = exp_q.pop_front();
                chk(dv_data == e, "R1", "beat octets", 64'(dv_data), 64'(e));
            end
        end else if (rst_n) begin
            chk(dv_sof == 6'd0, "R6", "mask on idle cycle", 64'(dv_sof), 64'd0);
        end
    end

    always @(posedge dev_clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [47:0] pd;
        bit pv;
        void'($urandom(32'd7741));

        // Phase 1: prefilled slots, exact release latency, full-rate stream
        do_reset(1'b0);
        credit = 9;
        wait (credit == 0);
        wait_dev(20);
        chk(dv_valid == 1'b0, "R2", "held with data buffered", 64'(dv_valid), 64'd0);
        @(negedge dev_clk);
        dv_release = 1'b1;
        release_seen = 1;
        stream_on = 1;
        @(negedge dev_clk);
        dv_release = 1'b0;
        chk(dv_valid == 1'b0, "R3", "one edge after release", 64'(dv_valid), 64'd0);
        @(negedge dev_clk);
        chk(dv_valid == 1'b1, "R3", "two edges after release", 64'(dv_valid), 64'd1);
        for (int i = 0; i < 200; i++) begin
            @(negedge dev_clk);
            chk(dv_valid == 1'b1, "R4", "beat every device clock", 64'(dv_valid), 64'd1);
        end
        chk(dv_unf == 1'b0, "R8", "no underflow at full rate", 64'(dv_unf), 64'd0);
        chk(lk_ovf == 1'b0, "R7", "no overflow at full rate", 64'(lk_ovf), 64'd0);
        stream_on = 0;
        wait_dev(30);
        chk(dv_unf == 1'b1, "R8", "underflow after input stops", 64'(dv_unf), 64'd1);
        chk(dv_valid == 1'b0, "R8", "idle while starved", 64'(dv_valid), 64'd0);
        chk(exp_q.size() == (words_sent % 3) * 4, "R5", "partial slot kept",
            64'(exp_q.size()), 64'((words_sent % 3) * 4));

        // Phase 2: release first, partial slot held, then gappy random input
        do_reset(1'b1);
        credit = 2;
        wait (credit == 0);
        pulse_release();
        seen = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge dev_clk);
            if (dv_valid) seen = 1;
        end
        chk(!seen, "R5", "two words never read", 64'(seen), 64'd0);
        gap_mode = 1;
        stream_on = 1;
        wait_dev(300);
        stream_on = 0;
        wait_dev(30);
        chk(beats >= 150, "R1", "beats delivered with gaps", 64'(beats), 64'd150);
        chk(exp_q.size() == (words_sent % 3) * 4, "R1", "nothing lost with gaps",
            64'(exp_q.size()), 64'((words_sent % 3) * 4));

        // Phase 3: overflow at exactly SLOT_DEPTH full slots
        do_reset(1'($urandom % 2));
        credit = 24;
        wait (credit == 0);
        wait_dev(10);
        chk(lk_ovf == 1'b0, "R7", "eight slots fit", 64'(lk_ovf), 64'd0);
        drop_next = 1;
        credit = 1;
        wait (credit == 0);
        wait_dev(4);
        chk(lk_ovf == 1'b1, "R7", "overflow on extra word", 64'(lk_ovf), 64'd1);
        chk(dv_valid == 1'b0, "R2", "no beat while unreleased", 64'(dv_valid), 64'd0);
        wait_dev(20);
        chk(lk_ovf == 1'b1, "R7", "overflow sticky", 64'(lk_ovf), 64'd1);
        pulse_release();
        wait_dev(40);
        chk(beats == 16, "R7", "stored slots drained", 64'(beats), 64'd16);
        chk(exp_q.size() == 0, "R7", "dropped word absent", 64'(exp_q.size()), 64'd0);
        chk(lk_ovf == 1'b1, "R7", "overflow held after drain", 64'(lk_ovf), 64'd1);

        // Phase 4: equal-width bypass instance
        do_reset(1'b1);
        bp_in = 48'h0102_0304_0506;
        bp_in_valid = 1'b1;
        @(negedge dev_clk);
        chk(bp_valid == 1'b0, "R10", "bypass held before release", 64'(bp_valid), 64'd0);
        bp_release = 1'b1;
        @(negedge dev_clk);
        bp_release = 1'b0;
        chk(bp_valid == 1'b0, "R10", "bypass on release edge", 64'(bp_valid), 64'd0);
        for (int i = 0; i < 40; i++) begin
            pv = 1'($urandom % 2);
            pd = {16'($urandom), $urandom};
            bp_in = pd;
            bp_in_valid = pv;
            @(negedge dev_clk);
            chk(bp_valid == pv, "R10", "bypass valid", 64'(bp_valid), 64'(pv));
            if (pv) chk(bp_out == pd, "R10", "bypass data", 64'(bp_out), 64'(pd));
            chk(bp_sof == (pv ? 6'b000001 : 6'b000000), "R10", "bypass mask",
                64'(bp_sof), 64'(pv ? 6'b000001 : 6'b000000));
        end
        chk(bp_ovf == 1'b0 && bp_unf == 1'b0, "R10", "bypass flags",
            64'({bp_ovf, bp_unf}), 64'd0);

        summary();
        $finish;
    end
endmodule